// File: doc/BRIEF.md
# Multi-Channel Interrupt Aggregator with Edge-Selectable Latching

This block collects interrupt conditions from a line interface with a configurable number of channels and presents them to a host through a plain register read/write port. Each channel supplies ten level conditions and nine single-cycle event pulses. The device as a whole adds one global event, a one-second timer tick. Level conditions are first captured in a status register. A transition of that status then latches a sticky flag. Per edge group, software chooses whether the flag is set only on a rising change or on any change. Event pulses latch their flags directly.

Flags stay set until the host writes one to their bit position. They latch whether or not they are masked. Every flag has a mask bit, and one global mask blocks everything. The unmasked flags of each channel reduce to one summary bit per channel. The summary bits and the global timer flag reduce to a single active-low interrupt pin. The summary bits are produced combinationally from registered state and can also be read back in groups of eight.

Top module: `irq_edge_ctl`

## Requirements
- R1: The status word of channel c, read at address 4c (bits 9:0), equals the level condition inputs of that channel as sampled on the previous clock edge.
- R2: Edge select register at address 4c+3 has 7 bits. Bit 0 governs level sources 0 and 1, bits 1..4 govern sources 2..5 one each, bit 5 governs sources 6 and 7, and bit 6 governs sources 8 and 9. With the bit at 0, a source's flag sets on a 0-to-1 status change only. With the bit at 1, it sets on a change in either direction.
- R3: An event pulse on evt_pulse[9c+j] sets flag bit 10+j of channel c on the next edge. A pulse on tick_sec sets the timer flag, read at bit 0 of address 4N+1.
- R4: Writing 1 to a flag bit (address 4c+1 for channel c, address 4N+1 for the timer) clears that flag. Writing 0 leaves it unchanged.
- R5: When a set condition and a write-1-to-clear of the same flag arrive in the same cycle, the flag is set afterwards.
- R6: Flags latch regardless of their mask bits.
- R7: chan_pend[c] is 1 exactly when channel c has a flag that is set and not masked while the global mask is 0. Summary register k at address 4N+2+k holds chan_pend[8k+7:8k] in bits 7:0.
- R8: irq_n is 0 exactly when some chan_pend bit is 1, or when the timer flag is set with the timer mask and the global mask both at 0.
- R9: After reset, all flags and status bits are 0, every mask bit is 1, the global and timer masks are 1, and the edge select bits are 0.
- R10: The mask register at 4c+2 (bits 18:0) and the control register at 4N (bit 0 global mask, bit 1 timer mask) read back what was written. Status is read-only. Addresses beyond 4N+1+ceil(N/8) read 0, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lvl_raw | input | NCH*10 | Level conditions, 10 per channel |
| evt_pulse | input | NCH*9 | Event pulses, 9 per channel |
| tick_sec | input | 1 | Global one-second timer event |
| wr_en | input | 1 | Register write strobe |
| addr | input | AW | Register address (read and write) |
| wdata | input | DW | Write data |
| rdata | output | DW | Read data for addr, combinational |
| chan_pend | output | NCH | Per-channel summary bits |
| irq_n | output | 1 | Active-low interrupt request |

## Verification
The hardest case to reach from the ports is a host clear that lands in the same cycle as a fresh set of the same flag. The either-edge case is also hard to reach, because a falling transition on one member of a shared edge group must be told apart from a rising one on its partner. Directed sequences set up both cases on purpose. Long random runs then toggle levels and pulse events sparsely and mix in write-one clears with random data. Those runs make such coincidences and falling edges recur many times under changing masks.

// File: rtl/irq_ctl_pkg.sv
package irq_ctl_pkg;

    localparam int NLVL = 10;
    localparam int NEVT = 9;
    localparam int NSRC = NLVL + NEVT;
    localparam int NGRP = 7;

    // Edge group owning a level source; pairs share a group.
    function automatic int grp_of(input int src);
        if (src < 2)      return 0;
        else if (src < 6) return src - 1;
        else if (src < 8) return 5;
        else              return 6;
    endfunction

    typedef struct packed {
        logic [NLVL-1:0] stat;
        logic [NSRC-1:0] flag;
        logic [NSRC-1:0] mask;
        logic [NGRP-1:0] esel;
    } chan_state_t;

    typedef struct packed {
        logic gmask;
        logic tmask;
        logic tflag;
    } glb_state_t;

endpackage

// File: rtl/irq_chan_src.sv
module irq_chan_src
    import irq_ctl_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NLVL-1:0] raw_i,
    input  logic [NEVT-1:0] evt_i,
    input  logic            wr_flag_i,
    input  logic            wr_mask_i,
    input  logic            wr_esel_i,
    input  logic [NSRC-1:0] wdata_i,
    output logic [NLVL-1:0] stat_o,
    output logic [NSRC-1:0] flag_o,
    output logic [NSRC-1:0] mask_o,
    output logic [NGRP-1:0] esel_o
);

    localparam chan_state_t CHAN_RST = '{
        stat: '0,
        flag: '0,
        mask: '1,
        esel: '0
    };

    chan_state_t s_d, s_q;
    logic [NSRC-1:0] hit_d;
    logic [NSRC-1:0] clr_d;

    always_comb begin
        s_d   = s_q;
        hit_d = '0;
        for (int i = 0; i < NLVL; i++) begin
            if (s_q.esel[grp_of(i)])
                hit_d[i] = s_q.stat[i] ^ raw_i[i];
            else
                hit_d[i] = ~s_q.stat[i] & raw_i[i];
        end
        hit_d[NSRC-1:NLVL] = evt_i;
        clr_d = wr_flag_i ? wdata_i : '0;
        s_d.flag = (s_q.flag & ~clr_d) | hit_d;
        s_d.stat = raw_i;
        if (wr_mask_i) s_d.mask = wdata_i;
        if (wr_esel_i) s_d.esel = wdata_i[NGRP-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= CHAN_RST;
        else        s_q <= s_d;
    end

    assign stat_o = s_q.stat;
    assign flag_o = s_q.flag;
    assign mask_o = s_q.mask;
    assign esel_o = s_q.esel;

endmodule

// File: rtl/irq_glb.sv
module irq_glb
    import irq_ctl_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic tick_i,
    input  logic wr_ctrl_i,
    input  logic wr_tflag_i,
    input  logic [1:0] wdata_i,
    output logic gmask_o,
    output logic tmask_o,
    output logic tflag_o
);

    localparam glb_state_t GLB_RST = '{gmask: 1'b1, tmask: 1'b1, tflag: 1'b0};

    glb_state_t g_d, g_q;

    always_comb begin
        g_d = g_q;
        if (wr_ctrl_i) begin
            g_d.gmask = wdata_i[0];
            g_d.tmask = wdata_i[1];
        end
        g_d.tflag = (g_q.tflag & ~(wr_tflag_i & wdata_i[0])) | tick_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) g_q <= GLB_RST;
        else        g_q <= g_d;
    end

    assign gmask_o = g_q.gmask;
    assign tmask_o = g_q.tmask;
    assign tflag_o = g_q.tflag;

endmodule

// File: rtl/irq_rollup.sv
module irq_rollup
    import irq_ctl_pkg::*;
#(
    parameter int NCH = 21
) (
    input  logic [NCH*NSRC-1:0] flag_i,
    input  logic [NCH*NSRC-1:0] mask_i,
    input  logic                gmask_i,
    input  logic                tflag_i,
    input  logic                tmask_i,
    output logic [NCH-1:0]      pend_o,
    output logic                irq_n_o
);

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        assign pend_o[c] = ~gmask_i &
            (|(flag_i[c*NSRC +: NSRC] & ~mask_i[c*NSRC +: NSRC]));
    end

    assign irq_n_o = ~((|pend_o) | (tflag_i & ~tmask_i & ~gmask_i));

endmodule

// File: rtl/irq_edge_ctl.sv
module irq_edge_ctl
    import irq_ctl_pkg::*;
#(
    parameter  int NCH   = 21,
    parameter  int DW    = 32,
    localparam int NSUM  = (NCH + 7) / 8,
    localparam int GBASE = NCH * 4,
    localparam int AW    = $clog2(GBASE + 2 + NSUM)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NCH*NLVL-1:0] lvl_raw,
    input  logic [NCH*NEVT-1:0] evt_pulse,
    input  logic                tick_sec,
    input  logic                wr_en,
    input  logic [AW-1:0]       addr,
    input  logic [DW-1:0]       wdata,
    output logic [DW-1:0]       rdata,
    output logic [NCH-1:0]      chan_pend,
    output logic                irq_n
);

    logic [NCH*NLVL-1:0] stat_flat;
    logic [NCH*NSRC-1:0] flag_flat;
    logic [NCH*NSRC-1:0] mask_flat;
    logic [NCH*NGRP-1:0] esel_flat;
    logic                glb_mask, tmr_mask, tmr_flag;
    logic [NSUM*8-1:0]   sum_pad;

    logic     is_ch;
    int       ch_i;
    int       off;
    logic [1:0] rsel;

    always_comb begin
        is_ch = int'(addr) < GBASE;
        ch_i  = int'(addr) >> 2;
        off   = int'(addr) - GBASE;
        rsel  = addr[1:0];
    end

    for (genvar c = 0; c < NCH; c++) begin : g_chan
        logic sel;
        assign sel = wr_en & is_ch & (ch_i == c);
        irq_chan_src u_src (
            .clk      (clk),
            .rst_n    (rst_n),
            .raw_i    (lvl_raw[c*NLVL +: NLVL]),
            .evt_i    (evt_pulse[c*NEVT +: NEVT]),
            .wr_flag_i(sel & (rsel == 2'd1)),
            .wr_mask_i(sel & (rsel == 2'd2)),
            .wr_esel_i(sel & (rsel == 2'd3)),
            .wdata_i  (wdata[NSRC-1:0]),
            .stat_o   (stat_flat[c*NLVL +: NLVL]),
            .flag_o   (flag_flat[c*NSRC +: NSRC]),
            .mask_o   (mask_flat[c*NSRC +: NSRC]),
            .esel_o   (esel_flat[c*NGRP +: NGRP])
        );
    end

    irq_glb u_glb (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick_i    (tick_sec),
        .wr_ctrl_i (wr_en & (off == 0)),
        .wr_tflag_i(wr_en & (off == 1)),
        .wdata_i   (wdata[1:0]),
        .gmask_o   (glb_mask),
        .tmask_o   (tmr_mask),
        .tflag_o   (tmr_flag)
    );

    irq_rollup #(.NCH(NCH)) u_roll (
        .flag_i (flag_flat),
        .mask_i (mask_flat),
        .gmask_i(glb_mask),
        .tflag_i(tmr_flag),
        .tmask_i(tmr_mask),
        .pend_o (chan_pend),
        .irq_n_o(irq_n)
    );

    always_comb begin
        sum_pad = '0;
        sum_pad[NCH-1:0] = chan_pend;
    end

    always_comb begin
        rdata = '0;
        if (is_ch) begin
            unique case (rsel)
                2'd0: rdata[NLVL-1:0] = stat_flat[ch_i*NLVL +: NLVL];
                2'd1: rdata[NSRC-1:0] = flag_flat[ch_i*NSRC +: NSRC];
                2'd2: rdata[NSRC-1:0] = mask_flat[ch_i*NSRC +: NSRC];
                default: rdata[NGRP-1:0] = esel_flat[ch_i*NGRP +: NGRP];
            endcase
        end else if (off == 0) begin
            rdata[1:0] = {tmr_mask, glb_mask};
        end else if (off == 1) begin
            rdata[0] = tmr_flag;
        end else if (off >= 2 && off < 2 + NSUM) begin
            rdata[7:0] = sum_pad[(off-2)*8 +: 8];
        end
    end

endmodule

// File: rtl/irq_edge_ctl_chk.sv
module irq_edge_ctl_chk
    import irq_ctl_pkg::*;
#(
    parameter int NCH = 21
) (
    input logic                clk,
    input logic                rst_n,
    input logic [NCH*NLVL-1:0] lvl_raw,
    input logic [NCH*NEVT-1:0] evt_pulse,
    input logic                tick_sec,
    input logic [NCH*NLVL-1:0] stat_flat,
    input logic [NCH*NSRC-1:0] flag_flat,
    input logic                glb_mask,
    input logic                tmr_flag,
    input logic [NCH-1:0]      chan_pend,
    input logic                irq_n
);

    // R1
    status_tracks_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> stat_flat == $past(lvl_raw));

    // R3
    tick_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tick_sec |=> tmr_flag);

    // R7
    gmask_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        glb_mask |-> (irq_n && chan_pend == '0));

    // R8
    pend_pin_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|chan_pend) |-> !irq_n);

    for (genvar c = 0; c < NCH; c++) begin : g_c
        for (genvar j = 0; j < NEVT; j++) begin : g_e
            // R3 R5
            evt_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
                evt_pulse[c*NEVT+j] |=> flag_flat[c*NSRC+NLVL+j]);
        end
        for (genvar i = 0; i < NLVL; i++) begin : g_l
            // R2
            rise_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (!stat_flat[c*NLVL+i] && lvl_raw[c*NLVL+i]) |=> flag_flat[c*NSRC+i]);
        end
    end

endmodule

bind irq_edge_ctl irq_edge_ctl_chk #(.NCH(NCH)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .lvl_raw  (lvl_raw),
    .evt_pulse(evt_pulse),
    .tick_sec (tick_sec),
    .stat_flat(stat_flat),
    .flag_flat(flag_flat),
    .glb_mask (glb_mask),
    .tmr_flag (tmr_flag),
    .chan_pend(chan_pend),
    .irq_n    (irq_n)
);

// File: tb/tb_irq_edge_ctl.sv
`timescale 1ns/1ps
module tb_irq_edge_ctl;

    localparam int NCH = 21;
    localparam int NL  = 10;
    localparam int NE  = 9;
    localparam int NS  = 19;
    localparam int NSUM = (NCH + 7) / 8;
    localparam int GB  = NCH * 4;
    localparam int AW  = $clog2(GB + 2 + NSUM);
    localparam int DW  = 32;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [NCH*NL-1:0] lvl_raw = '0;
    logic [NCH*NE-1:0] evt_pulse = '0;
    logic              tick_sec = 1'b0;
    logic              wr_en = 1'b0;
    logic [AW-1:0]     addr = '0;
    logic [DW-1:0]     wdata = '0;
    logic [DW-1:0]     rdata;
    logic [NCH-1:0]    chan_pend;
    logic              irq_n;

    always #10 clk = ~clk;

    irq_edge_ctl #(.NCH(NCH), .DW(DW)) dut (
        .clk(clk), .rst_n(rst_n), .lvl_raw(lvl_raw), .evt_pulse(evt_pulse),
        .tick_sec(tick_sec), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .rdata(rdata), .chan_pend(chan_pend), .irq_n(irq_n)
    );

    bit [NL-1:0] m_stat [NCH];
    bit [NS-1:0] m_flag [NCH];
    bit [NS-1:0] m_mask [NCH];
    bit [6:0]    m_esel [NCH];
    bit          m_gm, m_tm, m_tf;

    int    n_chk = 0;
    int    n_bad = 0;
    string tag_ovr = "";

    function automatic int grp(int i);
        case (i)
            0, 1: return 0;
            2: return 1;
            3: return 2;
            4: return 3;
            5: return 4;
            6, 7: return 5;
            default: return 6;
        endcase
    endfunction

    function automatic bit [NCH-1:0] exp_pend();
        bit [NCH-1:0] p;
        for (int c = 0; c < NCH; c++) p[c] = !m_gm && ((m_flag[c] & ~m_mask[c]) != 0);
        return p;
    endfunction

    function automatic bit [DW-1:0] exp_read(int a);
        bit [DW-1:0] r = '0;
        bit [NSUM*8-1:0] sp = '0;
        sp[NCH-1:0] = exp_pend();
        if (a < GB) begin
            case (a % 4)
                0: r[NL-1:0] = m_stat[a/4];
                1: r[NS-1:0] = m_flag[a/4];
                2: r[NS-1:0] = m_mask[a/4];
                default: r[6:0] = m_esel[a/4];
            endcase
        end else if (a == GB) r[1:0] = {m_tm, m_gm};
        else if (a == GB + 1) r[0] = m_tf;
        else if (a < GB + 2 + NSUM) r[7:0] = sp[(a-GB-2)*8 +: 8];
        return r;
    endfunction

    function automatic string tag_for(int a);
        if (tag_ovr != "") return tag_ovr;
        if (a < GB) begin
            case (a % 4)
                0: return "R1";
                1: return "R3";
                2: return "R10";
                default: return "R2";
            endcase
        end
        if (a == GB + 1) return "R4";
        if (a >= GB + 2 && a < GB + 2 + NSUM) return "R7";
        return "R10";
    endfunction

    task automatic chk(string tag, logic [63:0] act, logic [63:0] exp, string what);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h at %0t", tag, what, act, exp, $time);
        end
    endtask

    task automatic model_step();
        int a = int'(addr);
        for (int c = 0; c < NCH; c++) begin
            bit [NS-1:0] hit = '0;
            bit [NS-1:0] clr = '0;
            for (int i = 0; i < NL; i++) begin
                bit r = lvl_raw[c*NL+i];
                if (m_esel[c][grp(i)]) hit[i] = m_stat[c][i] ^ r;
                else                   hit[i] = !m_stat[c][i] && r;
            end
            for (int j = 0; j < NE; j++) hit[NL+j] = evt_pulse[c*NE+j];
            if (wr_en && a == c*4 + 1) clr = wdata[NS-1:0];
            m_flag[c] = (m_flag[c] & ~clr) | hit;
            m_stat[c] = lvl_raw[c*NL +: NL];
            if (wr_en && a == c*4 + 2) m_mask[c] = wdata[NS-1:0];
            if (wr_en && a == c*4 + 3) m_esel[c] = wdata[6:0];
        end
        m_tf = (m_tf && !(wr_en && a == GB + 1 && wdata[0])) || tick_sec;
        if (wr_en && a == GB) begin
            m_gm = wdata[0];
            m_tm = wdata[1];
        end
    endtask

    // Called just after a falling edge with inputs already driven.
    task automatic cyc();
        #1;
        chk(tag_for(int'(addr)), 64'(rdata), 64'(exp_read(int'(addr))), "rdata");
        chk(tag_ovr != "" ? tag_ovr : "R7", 64'(chan_pend), 64'(exp_pend()), "chan_pend");
        chk(tag_ovr != "" ? tag_ovr : "R8", 64'(irq_n),
            64'(!((exp_pend() != 0) || (m_tf && !m_tm && !m_gm))), "irq_n");
        model_step();
        @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual hung expected finished");
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'h1c0ffee5));
        for (int c = 0; c < NCH; c++) begin
            m_stat[c] = '0; m_flag[c] = '0; m_mask[c] = '1; m_esel[c] = '0;
        end
        m_gm = 1; m_tm = 1; m_tf = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R9: every register at its reset value
        tag_ovr = "R9";
        for (int a = 0; a < (1 << AW); a++) begin
            addr = AW'(a);
            cyc();
        end

        // R6: masked event still latches
        tag_ovr = "R6";
        evt_pulse[3*NE+2] = 1'b1; addr = AW'(3*4+1);
        cyc();
        evt_pulse = '0;
        cyc();

        // R4: write zero keeps, write one clears
        tag_ovr = "R4";
        wr_en = 1; wdata = '0; cyc();
        wr_en = 0; cyc();
        wr_en = 1; wdata = 32'h1 << 12; cyc();
        wr_en = 0; cyc();

        // R5: set and clear in the same cycle
        tag_ovr = "R5";
        evt_pulse[5*NE] = 1'b1; wr_en = 1; addr = AW'(5*4+1); wdata = '1;
        cyc();
        evt_pulse = '0; wr_en = 0;
        cyc();

        // R2: either-edge on shared group of channel 0, rising-only on channel 1
        tag_ovr = "R2";
        wr_en = 1; addr = AW'(3); wdata = 32'h1; cyc();
        wr_en = 0; addr = AW'(1); lvl_raw[1] = 1'b1; cyc(); cyc();
        wr_en = 1; wdata = '1; cyc();
        wr_en = 0; lvl_raw[1] = 1'b0; cyc(); cyc();
        addr = AW'(5); lvl_raw[NL] = 1'b1; cyc();
        wr_en = 1; wdata = '1; cyc();
        wr_en = 0; lvl_raw[NL] = 1'b0; cyc(); cyc();

        // R8: unmask, then global mask
        tag_ovr = "R8";
        wr_en = 1; addr = AW'(5*4+2); wdata = '0; cyc();
        addr = AW'(GB); wdata = 32'h0; cyc();
        wr_en = 0; cyc();
        wr_en = 1; wdata = 32'h1; cyc();
        wr_en = 0; cyc();

        // Random phase
        tag_ovr = "";
        for (int n = 0; n < 5000; n++) begin
            for (int b = 0; b < NCH*NL; b++)
                if ($urandom % 12 == 0) lvl_raw[b] = ~lvl_raw[b];
            for (int b = 0; b < NCH*NE; b++)
                evt_pulse[b] = ($urandom % 20 == 0);
            tick_sec = ($urandom % 50 == 0);
            wr_en = 1'b0;
            addr = AW'($urandom % (1 << AW));
            if ($urandom % 3 == 0) begin
                int ch = $urandom % NCH;
                int k = $urandom % 8;
                wr_en = 1'b1;
                wdata = $urandom;
                case (k)
                    0, 1, 2, 3: addr = AW'(ch*4 + 1);
                    4: begin addr = AW'(ch*4 + 2); wdata = $urandom & $urandom; end
                    5: addr = AW'(ch*4 + 3);
                    6: begin addr = AW'(GB); wdata = {30'd0, ($urandom % 4 == 0), ($urandom % 4 == 0)}; end
                    default: ;
                endcase
            end
            cyc();
        end
        wr_en = 0; evt_pulse = '0; tick_sec = 0;
        for (int a = 0; a < (1 << AW); a++) begin
            addr = AW'(a);
            cyc();
        end

        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule